// File: doc/BRIEF.md
# Serial Sampling Converter Interface Model

This block models the digital side of an eight-channel, twelve-bit sampling converter that is reached over a sixteen-clock serial frame. A host lowers chip-select, toggles the serial clock and shifts a command word in on the data-in line. The model returns a data-out frame that carries the tag of the converted channel and a result. A parallel result input stands in for the analog core. The model also drives a track/hold indication and keeps a power state.

All pins are synchronized into the system clock domain and edge-detected there. Each serial clock falling edge advances data-out by one bit. Data-in is sampled on each rising edge. A frame takes effect only when all sixteen rising edges have been seen. In a full-shutdown state the data-out driver stays off. Leaving shutdown starts a wake-up window whose length is counted in system clock cycles. A frame that begins while the model is not fully powered is flagged as invalid.

Top module: `adc_serial_model`

## Requirements
- R1: After reset, dout_en_o, hold_o, invalid_o, powering_o and shutdown_o are 0, and ctrl_o is 12'h060 (channel 0, power code 2'b11).
- R2: hold_o rises when a chip-select falling edge is seen. It falls when the 14th serial-clock falling edge of the frame is seen.
- R3: In a powered frame, dout_en_o is 1 while chip-select is low. The 16 data-out bits come out MSB first: a 0, then the 3-bit channel field of ctrl_o, then result_i. Both the channel and the result are taken when chip-select falls. The first bit is valid after the chip-select fall, and each serial-clock falling edge moves to the next bit.
- R4: Data-in is sampled MSB first on serial-clock rising edges. When the 16th rising edge is seen and the first bit (WRITE) is 1, ctrl_o takes the first 12 bits. Bit 11 of ctrl_o is WRITE, bit 10 is SEQ, bits 9:7 are the channel, bits 6:5 are the power code, bit 4 is SHADOW and bits 3:0 are spare.
- R5: A complete frame whose WRITE bit is 0 leaves ctrl_o, shadow_o and the power state unchanged.
- R6: A write with SEQ=0 and SHADOW=1 makes the next complete frame load all 16 data-in bits into shadow_o, with ctrl_o unchanged. The frame after that is a normal control frame again.
- R7: If chip-select rises before the 16th rising edge, ctrl_o, shadow_o and a pending shadow redirect are all left unchanged.
- R8: Power code 2'b10 puts the model into full shutdown at the chip-select rising edge, and shutdown_o goes to 1. ctrl_o is kept. While shut down, dout_en_o stays 0.
- R9: A write during shutdown with a power code other than 2'b10 starts wake-up at the chip-select rising edge. powering_o is then 1 for PWRUP_CYC system cycles, after which it returns to 0. The wake-up frame itself is not driven.
- R10: invalid_o is set at a chip-select fall when the model is shut down or powering, and cleared at a chip-select fall when it is fully powered. It keeps its value until the next chip-select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip-select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, idles high, asynchronous |
| din_i | input | 1 | Serial data in |
| result_i | input | 12 | Conversion result from the analog stand-in |
| dout_o | output | 1 | Serial data out |
| dout_en_o | output | 1 | Data-out drive enable (0 = high impedance) |
| hold_o | output | 1 | Sampler in hold |
| invalid_o | output | 1 | Current frame started before full power |
| powering_o | output | 1 | Wake-up window running |
| shutdown_o | output | 1 | Full shutdown state |
| ctrl_o | output | 12 | Control register |
| shadow_o | output | 16 | Shadow register |

## Verification
The bench builds the block with PWRUP_CYC=40 and two synchronizer stages. This keeps a wake-up window much shorter than one serial frame, so both the start and the end of powering can be checked within one short run. It sweeps every channel tag and a set of edge result patterns through back-to-back frames. It also runs the shadow redirect, aborted frames, and the shutdown and wake-up sequences.

// File: rtl/adc_pkg.sv
package adc_pkg;
  localparam int RES_W      = 12;
  localparam int CH_W       = 3;
  localparam int FRAME_W    = 1 + CH_W + RES_W;
  localparam int CTRL_W     = 12;
  localparam int TRACK_EDGE = 14;

  // control field positions inside ctrl word
  localparam int CW_WRITE   = 11;
  localparam int CW_SEQ     = 10;
  localparam int CW_ADDR_LO = 7;
  localparam int CW_PM_LO   = 5;
  localparam int CW_SHADOW  = 4;

  localparam logic [1:0] PM_ON  = 2'b11;
  localparam logic [1:0] PM_OFF = 2'b10;

  typedef enum logic [1:0] {
    PWR_ON   = 2'd0,
    PWR_OFF  = 2'd1,
    PWR_WAKE = 2'd2
  } pwr_e;
endpackage

// File: rtl/adc_sync_edge.sv
module adc_sync_edge #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine
  import adc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_lvl_i,
  input  logic               cs_fall_i,
  input  logic               cs_rise_i,
  input  logic               sclk_rise_i,
  input  logic               sclk_fall_i,
  input  logic               din_i,
  input  logic               drive_ok_i,
  input  logic [FRAME_W-1:0] load_i,
  output logic               dout_o,
  output logic               dout_en_o,
  output logic               hold_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_END   = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_TRACK = CNT_W'(TRACK_EDGE);
  localparam logic [CNT_W-1:0] CNT_PRE   = CNT_W'(TRACK_EDGE - 1);

  logic               active_q, en_q, hold_q, done_q;
  logic [CNT_W-1:0]   fcnt_q, rcnt_q;
  logic [FRAME_W-1:0] sout_q, sin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      en_q     <= 1'b0;
      hold_q   <= 1'b0;
      done_q   <= 1'b0;
      fcnt_q   <= '0;
      rcnt_q   <= '0;
      sout_q   <= '0;
      sin_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (cs_fall_i) begin
        active_q <= 1'b1;
        en_q     <= drive_ok_i;
        hold_q   <= 1'b1;
        fcnt_q   <= '0;
        rcnt_q   <= '0;
        sout_q   <= load_i;
      end else if (cs_rise_i) begin
        active_q <= 1'b0;
        en_q     <= 1'b0;
        hold_q   <= 1'b0;
      end else if (active_q) begin
        if (sclk_fall_i && fcnt_q < CNT_END) begin
          fcnt_q <= fcnt_q + CNT_W'(1);
          sout_q <= {sout_q[FRAME_W-2:0], 1'b0};
          if (fcnt_q == CNT_PRE) hold_q <= 1'b0;
        end
        if (sclk_rise_i && rcnt_q < CNT_END) begin
          rcnt_q <= rcnt_q + CNT_W'(1);
          sin_q  <= {sin_q[FRAME_W-2:0], din_i};
          if (rcnt_q == CNT_LAST) done_q <= 1'b1;
        end
      end
    end
  end

  assign dout_o    = sout_q[FRAME_W-1] & en_q;
  assign dout_en_o = en_q & active_q;
  assign hold_o    = hold_q;
  assign done_o    = done_q;
  assign word_o    = sin_q;

  AST_TRACK_AFTER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcnt_q >= CNT_TRACK) |-> !hold_o); // R2
  AST_DRIVE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_en_o && cs_lvl_i) |-> cs_rise_i); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
endmodule

// File: rtl/adc_power_ctrl.sv
module adc_power_ctrl
  import adc_pkg::*;
#(
  parameter int PWRUP_CYC = 400
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_fall_i,
  input  logic       cs_rise_i,
  input  logic [1:0] pm_i,
  output logic       powering_o,
  output logic       shutdown_o,
  output logic       invalid_o,
  output logic       drive_ok_o
);
  localparam int CNT_W = $clog2(PWRUP_CYC + 2);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PWRUP_CYC);

  pwr_e             state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             invalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PWR_ON;
      cnt_q     <= '0;
      invalid_q <= 1'b0;
    end else begin
      if (cs_fall_i) invalid_q <= (state_q != PWR_ON);
      if (cs_rise_i) begin
        if (state_q == PWR_OFF) begin
          if (pm_i != PM_OFF) begin
            if (PWRUP_CYC == 0) state_q <= PWR_ON;
            else begin
              state_q <= PWR_WAKE;
              cnt_q   <= CNT_LOAD;
            end
          end
        end else if (pm_i == PM_OFF) begin
          state_q <= PWR_OFF;
          cnt_q   <= '0;
        end
      end else if (state_q == PWR_WAKE) begin
        if (cnt_q <= CNT_W'(1)) begin
          state_q <= PWR_ON;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign powering_o = (state_q == PWR_WAKE);
  assign shutdown_o = (state_q == PWR_OFF);
  assign drive_ok_o = (state_q != PWR_OFF);
  assign invalid_o  = invalid_q;

  AST_WAKE_FROM_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(powering_o) |-> $past(shutdown_o)); // R9
  AST_EARLY_FRAME_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (powering_o && cs_fall_i) |=> invalid_o); // R10
endmodule

// File: rtl/adc_serial_model.sv
module adc_serial_model
  import adc_pkg::*;
#(
  parameter int PWRUP_CYC   = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sclk_i,
  input  logic               din_i,
  input  logic [RES_W-1:0]   result_i,
  output logic               dout_o,
  output logic               dout_en_o,
  output logic               hold_o,
  output logic               invalid_o,
  output logic               powering_o,
  output logic               shutdown_o,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [FRAME_W-1:0] shadow_o
);
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(PM_ON) << CW_PM_LO;

  logic cs_lvl, cs_rise, cs_fall;
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic din_lvl, din_rise, din_fall;
  logic frame_done, drive_ok;
  logic [FRAME_W-1:0] frame_word, frame_load;
  logic [CTRL_W-1:0]  ctrl_q, new_ctrl;
  logic [FRAME_W-1:0] shadow_q;
  logic               shadow_pend_q;

  adc_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk_i, .rst_ni, .async_i(cs_ni),
    .level_o(cs_lvl), .rise_o(cs_rise), .fall_o(cs_fall));
  adc_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
    .clk_i, .rst_ni, .async_i(sclk_i),
    .level_o(sclk_lvl), .rise_o(sclk_rise), .fall_o(sclk_fall));
  adc_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_din_sync (
    .clk_i, .rst_ni, .async_i(din_i),
    .level_o(din_lvl), .rise_o(din_rise), .fall_o(din_fall));

  assign frame_load = {1'b0, ctrl_q[CW_ADDR_LO +: CH_W], result_i};

  adc_frame_engine u_frame (
    .clk_i, .rst_ni,
    .cs_lvl_i(cs_lvl), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .din_i(din_lvl), .drive_ok_i(drive_ok), .load_i(frame_load),
    .dout_o, .dout_en_o, .hold_o, .done_o(frame_done), .word_o(frame_word));

  adc_power_ctrl #(.PWRUP_CYC(PWRUP_CYC)) u_power (
    .clk_i, .rst_ni, .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .pm_i(ctrl_q[CW_PM_LO +: 2]),
    .powering_o, .shutdown_o, .invalid_o, .drive_ok_o(drive_ok));

  assign new_ctrl = frame_word[FRAME_W-1 -: CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q        <= CTRL_RST;
      shadow_q      <= '0;
      shadow_pend_q <= 1'b0;
    end else if (frame_done) begin
      if (shadow_pend_q) begin
        shadow_q      <= frame_word;
        shadow_pend_q <= 1'b0;
      end else if (new_ctrl[CW_WRITE]) begin
        ctrl_q        <= new_ctrl;
        shadow_pend_q <= ~new_ctrl[CW_SEQ] & new_ctrl[CW_SHADOW];
      end
    end
  end

  assign ctrl_o   = ctrl_q;
  assign shadow_o = shadow_q;

  AST_CTRL_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done |=> $stable(ctrl_q)); // R7
  AST_SHADOW_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done |=> $stable(shadow_q)); // R7
  AST_SHUT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> !dout_en_o); // R8
endmodule

// File: tb/sim_adc_serial_model.sv
module sim_adc_serial_model;
  localparam int PWRUP = 40;
  localparam int HALF  = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, sclk_i = 1'b1, din_i = 1'b0;
  logic [11:0] result_i = '0;
  logic        dout_o, dout_en_o, hold_o, invalid_o, powering_o, shutdown_o;
  logic [11:0] ctrl_o;
  logic [15:0] shadow_o;

  int total = 0, bad = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  adc_serial_model #(.PWRUP_CYC(PWRUP), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni, .cs_ni, .sclk_i, .din_i, .result_i,
    .dout_o, .dout_en_o, .hold_o, .invalid_o, .powering_o, .shutdown_o,
    .ctrl_o, .shadow_o);

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input bit wr, input bit seq, input int ch,
                                     input logic [1:0] pm, input bit shd);
    return {wr, seq, 3'(ch), pm, shd, 8'h00};
  endfunction

  logic [15:0] got;
  bit en_all, en_none, hold_ok, inv_seen;

  task automatic xfer(input logic [15:0] w, input int nclk);
    got = '0; en_all = 1'b1; en_none = 1'b1; hold_ok = 1'b1;
    cs_ni = 1'b0;
    tick(6);
    hold_ok &= (hold_o === 1'b1);
    inv_seen = invalid_o;
    got[15] = dout_o; en_all &= dout_en_o; en_none &= !dout_en_o;
    for (int i = 0; i < nclk; i++) begin
      sclk_i = 1'b0;
      din_i  = w[15-i];
      tick(HALF);
      if (i < 15) begin
        got[14-i] = dout_o; en_all &= dout_en_o; en_none &= !dout_en_o;
      end
      if (i == 12) hold_ok &= (hold_o === 1'b1);
      if (i == 13) hold_ok &= (hold_o === 1'b0);
      sclk_i = 1'b1;
      tick(HALF);
    end
    cs_ni = 1'b1;
    tick(6);
  endtask

  initial begin
    int prev_ch;
    logic [11:0] res, ctl;
    tick(3);
    rst_ni = 1'b1;
    tick(3);
    // R1 reset state
    chk("R1 dout_en", dout_en_o, 0);
    chk("R1 hold", hold_o, 0);
    chk("R1 invalid", invalid_o, 0);
    chk("R1 powering", powering_o, 0);
    chk("R1 shutdown", shutdown_o, 0);
    chk("R1 ctrl", ctrl_o, 12'h060);

    // R3 R4 R2: channel sweep, tag of frame = channel written previously
    prev_ch = 0;
    for (int k = 0; k < 9; k++) begin
      res = 12'((k * 517 + 123) & 12'hfff);
      result_i = res;
      xfer(cw(1, 0, k % 8, 2'b11, 0), 16);
      chk("R3 frame", got, {1'b0, 3'(prev_ch), res});
      chk("R3 drive", en_all, 1);
      chk("R2 hold", hold_ok, 1);
      chk("R4 ctrl", ctrl_o, cw(1, 0, k % 8, 2'b11, 0) >> 4);
      chk("R10 valid", inv_seen, 0);
      prev_ch = k % 8;
    end
    // R3 result patterns on channel 5
    xfer(cw(1, 0, 5, 2'b11, 0), 16);
    for (int p = 0; p < 5; p++) begin
      case (p)
        0: res = 12'h000;
        1: res = 12'hfff;
        2: res = 12'h800;
        3: res = 12'h001;
        default: res = 12'h555;
      endcase
      result_i = res;
      xfer(cw(1, 0, 5, 2'b11, 0), 16);
      chk("R3 pattern", got, {4'b0101, res});
    end

    // R5 write bit clear
    ctl = ctrl_o;
    xfer(cw(0, 1, 2, 2'b10, 1), 16);
    chk("R5 ctrl kept", ctrl_o, ctl);
    chk("R5 no shutdown", shutdown_o, 0);
    xfer(16'h1234, 16);
    chk("R5 no shadow redirect", shadow_o, 0);
    chk("R5 ctrl still", ctrl_o, ctl);

    // R6 shadow redirect
    xfer(cw(1, 0, 2, 2'b11, 1), 16);
    ctl = ctrl_o;
    chk("R6 setup ctrl", ctl, cw(1, 0, 2, 2'b11, 1) >> 4);
    xfer(16'hA5C3, 16);
    chk("R6 shadow", shadow_o, 16'hA5C3);
    chk("R6 ctrl kept", ctrl_o, ctl);
    xfer(cw(1, 0, 6, 2'b11, 0), 16);
    chk("R6 back to ctrl", ctrl_o, cw(1, 0, 6, 2'b11, 0) >> 4);
    chk("R6 shadow kept", shadow_o, 16'hA5C3);

    // R7 aborts
    xfer(cw(1, 0, 3, 2'b10, 0), 10);
    chk("R7 ctrl kept", ctrl_o, cw(1, 0, 6, 2'b11, 0) >> 4);
    chk("R7 hold released", hold_o, 0);
    xfer(cw(1, 0, 3, 2'b11, 1), 16);
    xfer(16'h1234, 12);
    chk("R7 shadow kept", shadow_o, 16'hA5C3);
    xfer(16'h00FF, 16);
    chk("R7 pending survives", shadow_o, 16'h00FF);
    chk("R7 ctrl after shadow", ctrl_o, cw(1, 0, 3, 2'b11, 1) >> 4);

    // R8 shutdown
    xfer(cw(1, 0, 4, 2'b10, 0), 16);
    chk("R8 shutdown", shutdown_o, 1);
    xfer(cw(0, 0, 0, 2'b11, 0), 16);
    chk("R8 undriven", en_none, 1);
    chk("R10 shut frame", inv_seen, 1);
    chk("R8 ctrl kept", ctrl_o, cw(1, 0, 4, 2'b10, 0) >> 4);
    chk("R8 still shut", shutdown_o, 1);

    // R9 wake-up timing
    xfer(cw(1, 0, 4, 2'b11, 0), 16);
    chk("R9 wake frame undriven", en_none, 1);
    chk("R9 powering", powering_o, 1);
    chk("R9 left shutdown", shutdown_o, 0);
    tick(PWRUP - 12);
    chk("R9 powering mid", powering_o, 1);
    tick(14);
    chk("R9 powered", powering_o, 0);
    result_i = 12'h3c5;
    xfer(cw(1, 0, 4, 2'b11, 0), 16);
    chk("R10 ready frame", inv_seen, 0);
    chk("R9 data after wake", got, {4'b0100, 12'h3c5});

    // R10 frame during wake-up
    xfer(cw(1, 0, 1, 2'b10, 0), 16);
    xfer(cw(1, 0, 1, 2'b11, 0), 16);
    chk("R10 pre powering", powering_o, 1);
    xfer(cw(1, 0, 1, 2'b11, 0), 16);
    chk("R10 early frame", inv_seen, 1);
    chk("R10 early driven", en_all, 1);
    chk("R10 flag held", invalid_o, 1);

    done_flag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule